// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O SRAM Core

This core is a small synchronous memory with separate write-data and read-data buses. Every access moves two words. The core runs on a beat clock at twice the command rate. It splits that clock into alternating beats: a first beat and a second beat. The first beat stands for the rising half of the command clock and the second for the falling half. A command is sampled only at the edge that opens a first beat. The inputs that a command edge samples are the load strobe, the read/write select and the pair address.

A write takes its first data word at the command edge and its second word at the next beat edge. It commits both words before the next command is sampled. A read presents its two words during the whole command cycle that follows it: word 0 on the first beat, word 1 on the second. An output enable marks the beats in which the read bus carries valid data, and the bus is held at zero otherwise. An echo clock is high during every first beat and low during every second beat. It runs without a break from the release of reset.

Top module: `burst2_sram`

## Requirements
- R1: When `ldN` is high at a command edge, the command is a deselect. The memory is left unchanged whatever `rdWr`, `addr` and `dataIn` carry. In the next command cycle `dataOe` is low on both beats.
- R2: When `ldN` is low and `rdWr` is high at a command edge, the command is a read. In the next command cycle, `dataOut` carries word 0 of pair `addr` on the first beat and word 1 on the second beat.
- R3: When `ldN` and `rdWr` are both low at a command edge, the command is a write. `dataIn` at that edge becomes word 0 of pair `addr`. `dataIn` at the following beat edge becomes word 1. The inputs `ldN`, `rdWr` and `addr` are ignored at that second edge, and writes to other pairs are left intact.
- R4: `dataOe` is high on both beats of a command cycle exactly when the previous command was a read. In the cycle that follows a write or deselect, `dataOe` is low, even when a read came just before that write or deselect.
- R5: Back-to-back reads keep `dataOe` high on every beat, with no idle beat between bursts.
- R6: A read sampled at the command edge right after a write to the same pair returns the new words. A read sampled just before a write to the same pair returns the old words.
- R7: `echoClk` is never disabled. It is high in every first beat and low in every second beat, so it changes at every beat edge after reset is released.
- R8: While `rst_n` is low, `dataOe`, `dataOut` and `echoClk` are low, and every memory word is cleared to zero. The first command edge is the first beat edge after reset is released.
- R9: `dataOut` is all zeros whenever `dataOe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, two edges per command cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ldN | input | 1 | Load strobe, low starts a read or write |
| rdWr | input | 1 | 1 selects read, 0 selects write |
| addr | input | AW | Pair address |
| dataIn | input | DW | Write data, word 0 then word 1 |
| dataOut | output | DW | Read data, word 0 then word 1 |
| dataOe | output | 1 | High while `dataOut` carries read data |
| echoClk | output | 1 | Command-rate echo clock, high in the first beat |

## Verification
The bench checks the hazards between neighbouring commands:
- A read right after a write to the same pair must see the new words. A core that committed late would return stale data.
- A read just before a write must see the old words. A core that forwarded too eagerly would return the new ones.
- A write that follows a read must still show the read data and then drop the enable. A core that tristated the bus when the write was sampled would cut the read burst short.
- Back-to-back reads must leave no gap in the enable.

The bench also changes `ldN`, `rdWr` and `addr` in the second beat, to show that a core sampling on both edges would corrupt the pair being written. A deselect is given write-looking inputs, to show that a core which ignored the load strobe would overwrite memory.

// File: rtl/burst2_sram_pkg.sv
package burst2_sram_pkg;

  // Strobes from control to datapath, valid for the coming beat edge.
  typedef struct packed {
    logic cmdEdge;   // this edge opens a command cycle
    logic wrCapture; // hold dataIn as word 0 of a write
    logic wrCommit;  // store held word 0 and dataIn as word 1
    logic rdLoad;    // load a read word onto the output bus
  } dpStrobe_t;

endpackage

// File: rtl/burst2_sram_ctrl.sv
module burst2_sram_ctrl
  import burst2_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldN,
  input  logic          rdWr,
  input  logic [AW-1:0] addr,
  output dpStrobe_t     strobe,
  output logic [AW-1:0] rdPair,
  output logic          rdBeat,
  output logic [AW-1:0] wrPair,
  output logic          echoClk
);

  logic          phaseQ;
  logic          rdPendQ;
  logic          rdOutQ;
  logic          wrPendQ;
  logic [AW-1:0] rdAddrQ;
  logic [AW-1:0] outAddrQ;
  logic [AW-1:0] wrAddrQ;

  logic cmdEdge;
  logic isRead;
  logic isWrite;

  assign cmdEdge = ~phaseQ;
  assign isRead  = ~ldN & rdWr;
  assign isWrite = ~ldN & ~rdWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseQ   <= 1'b0;
      rdPendQ  <= 1'b0;
      rdOutQ   <= 1'b0;
      wrPendQ  <= 1'b0;
      rdAddrQ  <= '0;
      outAddrQ <= '0;
      wrAddrQ  <= '0;
    end else begin
      phaseQ <= ~phaseQ;
      if (cmdEdge) begin
        rdOutQ   <= rdPendQ;
        outAddrQ <= rdAddrQ;
        rdPendQ  <= isRead;
        wrPendQ  <= isWrite;
        if (isRead)  rdAddrQ <= addr;
        if (isWrite) wrAddrQ <= addr;
      end
    end
  end

  always_comb begin
    strobe.cmdEdge   = cmdEdge;
    strobe.wrCapture = cmdEdge & isWrite;
    strobe.wrCommit  = phaseQ & wrPendQ;
    strobe.rdLoad    = cmdEdge ? rdPendQ : rdOutQ;
  end

  assign rdPair  = cmdEdge ? rdAddrQ : outAddrQ;
  assign rdBeat  = phaseQ;
  assign wrPair  = wrAddrQ;
  assign echoClk = phaseQ;

endmodule

// File: rtl/burst2_sram_dp.sv
module burst2_sram_dp
  import burst2_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] rdPair,
  input  logic          rdBeat,
  input  logic [AW-1:0] wrPair,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe
);

  localparam int PAIRS = 1 << AW;

  logic [DW-1:0] word0Q [PAIRS];
  logic [DW-1:0] word1Q [PAIRS];
  logic [DW-1:0] d0HoldQ;
  logic [DW-1:0] rdWord;
  logic [DW-1:0] outQ;
  logic          oeQ;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word0Q[p] <= '0;
        word1Q[p] <= '0;
      end else if (strobe.wrCommit && wrPair == AW'(p)) begin
        word0Q[p] <= d0HoldQ;
        word1Q[p] <= dataIn;
      end
    end
  end

  assign rdWord = rdBeat ? word1Q[rdPair] : word0Q[rdPair];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d0HoldQ <= '0;
      outQ    <= '0;
      oeQ     <= 1'b0;
    end else begin
      if (strobe.wrCapture) d0HoldQ <= dataIn;
      if (strobe.cmdEdge) oeQ <= strobe.rdLoad;
      if (strobe.rdLoad) outQ <= rdWord;
      else if (strobe.cmdEdge) outQ <= '0;
    end
  end

  assign dataOut = outQ;
  assign dataOe  = oeQ;

endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import burst2_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ldN,
  input  logic          rdWr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataOe,
  output logic          echoClk
);

  dpStrobe_t     strobe;
  logic [AW-1:0] rdPair;
  logic [AW-1:0] wrPair;
  logic          rdBeat;

  burst2_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ldN     (ldN),
    .rdWr    (rdWr),
    .addr    (addr),
    .strobe  (strobe),
    .rdPair  (rdPair),
    .rdBeat  (rdBeat),
    .wrPair  (wrPair),
    .echoClk (echoClk)
  );

  burst2_sram_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .rdPair  (rdPair),
    .rdBeat  (rdBeat),
    .wrPair  (wrPair),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ldN,
  input logic          rdWr,
  input logic [DW-1:0] dataOut,
  input logic          dataOe,
  input logic          echoClk
);

  // Set once a full beat has passed since reset release.
  logic armQ;
  always_ff @(posedge clk) begin
    if (!rst_n) armQ <= 1'b0;
    else        armQ <= 1'b1;
  end

  assert_echo_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armQ |-> (echoClk != $past(echoClk)));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOe |-> (dataOut == '0));

  assert_oe_held_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armQ && echoClk) |=> $stable(dataOe));

  assert_oe_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armQ && !echoClk && !ldN && rdWr) |=> ##2 dataOe);

  assert_idle_after_nonread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armQ && !echoClk && !(!ldN && rdWr)) |=> ##2 !dataOe);

endmodule

bind burst2_sram burst2_sram_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ldN     (ldN),
  .rdWr    (rdWr),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .echoClk (echoClk)
);

// File: tb/burst2_sram_tb.sv
`timescale 1ns/1ps
module burst2_sram_tb;

  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ldN = 1'b1;
  logic          rdWr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOe;
  logic          echoClk;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  logic [DW-1:0] gotQ0, gotQ1;
  logic          gotOe0, gotOe1, gotE0, gotE1;

  always #10 clk = ~clk;

  burst2_sram #(.AW(AW), .DW(DW)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ldN     (ldN),
    .rdWr    (rdWr),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .echoClk (echoClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One command cycle: starts and ends at a negedge before a command edge.
  // The outputs captured belong to the previous command.
  task automatic doCmd(input logic ld, input logic rw, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    ldN = ld; rdWr = rw; addr = a; dataIn = d0;
    @(posedge clk); @(negedge clk);
    gotQ0 = dataOut; gotOe0 = dataOe; gotE0 = echoClk;
    // second-beat inputs other than dataIn must be ignored
    ldN = ~ld; rdWr = ~rw; addr = ~a; dataIn = d1;
    @(posedge clk); @(negedge clk);
    gotQ1 = dataOut; gotOe1 = dataOe; gotE1 = echoClk;
  endtask

  task automatic deselect();
    doCmd(1'b1, 1'b0, '0, 16'h0, 16'h0);
  endtask

  task automatic expectRead(input string req, input logic [DW-1:0] q0, input logic [DW-1:0] q1);
    check({req, " oe beat0"}, 32'(gotOe0), 32'd1);
    check({req, " oe beat1"}, 32'(gotOe1), 32'd1);
    check({req, " word0"}, 32'(gotQ0), 32'(q0));
    check({req, " word1"}, 32'(gotQ1), 32'(q1));
  endtask

  task automatic expectIdle(input string req);
    check({req, " oe beat0"}, 32'(gotOe0), 32'd0);
    check({req, " oe beat1"}, 32'(gotOe1), 32'd0);
    check({req, " R9 bus zero beat0"}, 32'(gotQ0), 32'd0);
    check({req, " R9 bus zero beat1"}, 32'(gotQ1), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 oe in reset", 32'(dataOe), 32'd0);
    check("R8 bus in reset", 32'(dataOut), 32'd0);
    check("R8 echo in reset", 32'(echoClk), 32'd0);
    rst_n = 1'b1;
    doCmd(1'b0, 1'b1, 4'd3, 16'h0, 16'h0); // read cleared pair
    expectIdle("R8 first cycle");
    deselect();
    expectRead("R8 cleared memory", 16'h0, 16'h0);
  endtask

  task automatic t_write_read();
    doCmd(1'b0, 1'b0, 4'd5, 16'hA1A1, 16'hB2B2);
    expectIdle("R4 after deselect");
    doCmd(1'b0, 1'b0, 4'd6, 16'hC3C3, 16'hD4D4);
    expectIdle("R4 after write");
    doCmd(1'b0, 1'b1, 4'd5, 16'h0, 16'h0);
    deselect();
    expectRead("R2 R3 pair 5", 16'hA1A1, 16'hB2B2);
    check("R7 echo high in beat0", 32'(gotE0), 32'd1);
    check("R7 echo low in beat1", 32'(gotE1), 32'd0);
    doCmd(1'b0, 1'b1, 4'd6, 16'h0, 16'h0);
    deselect();
    expectRead("R3 neighbour pair 6", 16'hC3C3, 16'hD4D4);
  endtask

  task automatic t_deselect_ignored();
    doCmd(1'b1, 1'b0, 4'd5, 16'hDEAD, 16'hBEEF);
    expectIdle("R1 after deselect");
    doCmd(1'b1, 1'b1, 4'd5, 16'h1111, 16'h2222);
    expectIdle("R1 deselect with rdWr high");
    doCmd(1'b0, 1'b1, 4'd5, 16'h0, 16'h0);
    deselect();
    expectRead("R1 memory untouched", 16'hA1A1, 16'hB2B2);
  endtask

  task automatic t_back_to_back();
    doCmd(1'b0, 1'b1, 4'd5, 16'h0, 16'h0);
    doCmd(1'b0, 1'b1, 4'd6, 16'h0, 16'h0);
    expectRead("R5 first burst", 16'hA1A1, 16'hB2B2);
    doCmd(1'b0, 1'b1, 4'd5, 16'h0, 16'h0);
    expectRead("R5 second burst", 16'hC3C3, 16'hD4D4);
    deselect();
    expectRead("R5 third burst", 16'hA1A1, 16'hB2B2);
    deselect();
    expectIdle("R5 end of reads");
  endtask

  task automatic t_hazards();
    doCmd(1'b0, 1'b0, 4'd7, 16'h7070, 16'h7171);
    doCmd(1'b0, 1'b1, 4'd7, 16'h0, 16'h0);
    expectIdle("R4 after write");
    deselect();
    expectRead("R6 read after write", 16'h7070, 16'h7171);
    doCmd(1'b0, 1'b1, 4'd7, 16'h0, 16'h0);
    doCmd(1'b0, 1'b0, 4'd7, 16'h9090, 16'h9191);
    expectRead("R6 read before write", 16'h7070, 16'h7171);
    doCmd(1'b0, 1'b1, 4'd7, 16'h0, 16'h0);
    expectIdle("R4 write after read");
    deselect();
    expectRead("R6 newest data", 16'h9090, 16'h9191);
    doCmd(1'b0, 1'b1, 4'd5, 16'h0, 16'h0);
    deselect();
    deselect();
    expectIdle("R4 deselect after read");
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_deselect_ignored();
    t_back_to_back();
    t_hazards();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule